// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block decides which of three interrupt sources is serviced next. The sources are an external active-low request pin and two timer end-of-count strobes. Each event sets a bit in a pending register. Software can also load that register directly, so with every source disabled it can poll for work instead of taking interrupts. An enable register holds one bit per source and a global enable. A 3-bit ordering code picks one of six fixed permutations that rank the sources.

When the global enable is set, the ordering code is valid and at least one pending source is enabled, the block takes the highest-ranked of those sources. It does this on a clock edge: it raises a one-cycle grant pulse and reports the source number and the program-memory address of that source's 2-byte vector slot. On the same edge it clears the global enable and the granted pending bit. The core that receives the grant reads the vector and later sets the global enable again, either with an enable command or on return from the handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held and directly after it, `pend_q` is 000, `en_q` is 00h, `order_q` is 000, `grant` is 0 and `vec_addr` is 0.
- R2: A high cycle on `t0_eoc` sets `pend_q[1]`, and a high cycle on `t1_eoc` sets `pend_q[2]`. The bit is visible after the next rising clock edge.
- R3: `ext_req_n` passes through two synchroniser flops. Only a high-to-low transition sets `pend_q[0]`, visible three rising edges after the pin goes low. A pin that rises or stays low sets nothing further.
- R4: A `pend_wr` cycle replaces the pending register with `pend_wdata`, where bit 0 is the pin source, bit 1 is timer 0 and bit 2 is timer 1. Events still latch into the pending bits while every source is disabled, so software can poll them.
- R5: An `en_wr` cycle loads per-source enables from bits 2:0 and the global enable from bit 7 of `en_wdata`. `en_q` reads back `{global, 0000, enables}`, and bits 6:3 always read 0.
- R6: The block grants a source when that source is pending, its own enable is 1, the global enable is 1 and the ordering code is valid. `grant` is then high for the cycle after the edge that sees these conditions. With no eligible source, `grant` stays 0.
- R7: Ranks by ordering code, highest first, with source ids 0 = pin, 1 = timer 0, 2 = timer 1: 001 gives 1,2,0; 010 gives 2,0,1; 011 gives 2,1,0; 100 gives 0,1,2; 101 gives 1,0,2; 110 gives 0,2,1. `grant_src` holds the winner's id.
- R8: When the ordering code is 000 or 111, the block grants nothing. Pending bits still latch.
- R9: During a grant, `vec_addr` is 4 for id 0, 8 for id 1 and 10 for id 2.
- R10: A grant clears the global enable and the granted pending bit on the same edge that raises `grant`. If these fall in the same cycle, precedence runs lowest to highest: grant clear, then `en_wr` bit 7, then `gie_set`, then `gie_clr`.
- R11: If a new event for a source arrives in the same cycle that its pending bit is cleared, by a grant or a register write, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req_n | input | 1 | External request pin, active low, asynchronous |
| t0_eoc | input | 1 | Timer 0 end-of-count strobe |
| t1_eoc | input | 1 | Timer 1 end-of-count strobe |
| pend_wr | input | 1 | Write strobe for pending register |
| pend_wdata | input | 3 | Pending register write data |
| en_wr | input | 1 | Write strobe for enable register |
| en_wdata | input | 8 | Enable register write data (bit 7 global) |
| order_wr | input | 1 | Write strobe for ordering code |
| order_wdata | input | 3 | Ordering code write data |
| gie_set | input | 1 | Set global enable (enable or return command) |
| gie_clr | input | 1 | Clear global enable (disable command) |
| pend_q | output | 3 | Pending register |
| en_q | output | 8 | Enable register read value |
| order_q | output | 3 | Current ordering code |
| grant | output | 1 | One-cycle grant pulse |
| grant_src | output | 2 | Id of granted source |
| vec_addr | output | 16 | Vector slot address of granted source |

## Verification
A timer strobe shows in `pend_q` one edge after it is driven. A pin fall shows three edges after it is driven. A register write shows one edge after it is driven. A grant appears one edge after the edge that made its source eligible. For the sweeps this means the second edge after a `gie_set` cycle, and the cleared enable and pending bit appear in that same sample. The bench drives every stimulus just after a falling clock edge and checks just after the next falling edge that follows the counted number of rising edges. Where a value must not appear early, it also checks the edge before. The sweeps cover every ordering code against every non-empty pending set, and every enable pattern under two codes. They also cover the collision of a new event with a clear.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_req_n,
  input  logic              t0_eoc,
  input  logic              t1_eoc,
  input  logic              pend_wr,
  input  logic [2:0]        pend_wdata,
  input  logic              en_wr,
  input  logic [7:0]        en_wdata,
  input  logic              order_wr,
  input  logic [2:0]        order_wdata,
  input  logic              gie_set,
  input  logic              gie_clr,
  output logic [2:0]        pend_q,
  output logic [7:0]        en_q,
  output logic [2:0]        order_q,
  output logic              grant,
  output logic [1:0]        grant_src,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int NSRC = 3;
  localparam logic [ADDR_W-1:0] VEC_PIN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] VEC_T0  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] VEC_T1  = ADDR_W'(10);

  logic [SYNC_STAGES:0] pin_sh;
  logic [NSRC-1:0]      pend, events, elig, pend_nx;
  logic [NSRC-1:0]      en;
  logic                 gie, gie_nx;
  logic [2:0]           order;
  logic [5:0]           ranks;
  logic                 valid, found, take;
  logic [1:0]           win;
  logic                 grant_q;
  logic [1:0]           src_q;
  logic [ADDR_W-1:0]    vec_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sh <= '1;
    else        pin_sh <= {pin_sh[SYNC_STAGES-1:0], ext_req_n};

  assign events = {t1_eoc, t0_eoc, pin_sh[SYNC_STAGES] & ~pin_sh[SYNC_STAGES-1]};

  function automatic logic [5:0] rank_of(input logic [2:0] code);
    case (code)
      3'b001:  return {2'd0, 2'd2, 2'd1};
      3'b010:  return {2'd1, 2'd0, 2'd2};
      3'b011:  return {2'd0, 2'd1, 2'd2};
      3'b100:  return {2'd2, 2'd1, 2'd0};
      3'b101:  return {2'd2, 2'd0, 2'd1};
      3'b110:  return {2'd1, 2'd2, 2'd0};
      default: return {2'd2, 2'd1, 2'd0};
    endcase
  endfunction

  assign ranks = rank_of(order);
  assign valid = (order != 3'b000) && (order != 3'b111);
  assign elig  = pend & en & {NSRC{gie}};

  always_comb begin
    found = 1'b0;
    win   = 2'd0;
    for (int r = 0; r < NSRC; r++) begin
      if (!found && elig[ranks[2*r +: 2]]) begin
        found = 1'b1;
        win   = ranks[2*r +: 2];
      end
    end
  end

  assign take = found && valid;

  always_comb begin
    pend_nx = pend_wr ? pend_wdata : pend;
    if (take) pend_nx[win] = 1'b0;
    pend_nx = pend_nx | events;
  end

  always_comb begin
    gie_nx = take ? 1'b0 : gie;
    if (en_wr)   gie_nx = en_wdata[7];
    if (gie_set) gie_nx = 1'b1;
    if (gie_clr) gie_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend    <= '0;
      en      <= '0;
      gie     <= 1'b0;
      order   <= '0;
      grant_q <= 1'b0;
      src_q   <= '0;
      vec_q   <= '0;
    end else begin
      pend    <= pend_nx;
      gie     <= gie_nx;
      grant_q <= take;
      if (en_wr)    en    <= en_wdata[NSRC-1:0];
      if (order_wr) order <= order_wdata;
      if (take) begin
        src_q <= win;
        vec_q <= (win == 2'd0) ? VEC_PIN : (win == 2'd1) ? VEC_T0 : VEC_T1;
      end
    end

  assign pend_q    = pend;
  assign en_q      = {gie, 4'b0000, en};
  assign order_q   = order;
  assign grant     = grant_q;
  assign grant_src = src_q;
  assign vec_addr  = grant_q ? vec_q : '0;
endmodule

module prio_irq_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gie_set,
  input logic              en_wr,
  input logic [7:0]        en_wdata,
  input logic [2:0]        pend_q,
  input logic [7:0]        en_q,
  input logic [2:0]        order_q,
  input logic              grant,
  input logic [1:0]        grant_src,
  input logic [ADDR_W-1:0] vec_addr
);
  logic [2:0]        src_bit;
  logic [ADDR_W-1:0] vec_exp;
  assign src_bit = 3'b001 << grant_src;
  assign vec_exp = (grant_src == 2'd0) ? ADDR_W'(4) :
                   (grant_src == 2'd1) ? ADDR_W'(8) : ADDR_W'(10);

  // R6
  grant_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(en_q[7]));

  // R6
  grant_eligible_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (($past(pend_q & en_q[2:0]) & src_bit) != 3'b000));

  // R7
  grant_src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> grant_src != 2'd3);

  // R8
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ($past(order_q) != 3'b000 && $past(order_q) != 3'b111));

  // R9
  vector_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> vec_addr == vec_exp);

  // R10
  gie_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (!en_q[7] || $past(gie_set) || $past(en_wr && en_wdata[7])));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_req_n = 1'b1, t0_eoc = 1'b0, t1_eoc = 1'b0;
  logic        pend_wr = 1'b0, en_wr = 1'b0, order_wr = 1'b0;
  logic [2:0]  pend_wdata = '0, order_wdata = '0;
  logic [7:0]  en_wdata = '0;
  logic        gie_set = 1'b0, gie_clr = 1'b0;
  logic [2:0]  pend_q, order_q;
  logic [7:0]  en_q;
  logic        grant;
  logic [1:0]  grant_src;
  logic [15:0] vec_addr;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_win(input int code, input bit [2:0] el);
    int ord[3];
    case (code)
      1: ord = '{1, 2, 0};
      2: ord = '{2, 0, 1};
      3: ord = '{2, 1, 0};
      4: ord = '{0, 1, 2};
      5: ord = '{1, 0, 2};
      6: ord = '{0, 2, 1};
      default: return -1;
    endcase
    for (int i = 0; i < 3; i++) if (el[ord[i]]) return ord[i];
    return -1;
  endfunction

  function automatic int exp_vec(input int id);
    int num = (id == 0) ? 2 : id + 3;
    return 2 * num;
  endfunction

  task automatic arm_and_check(input int code, input bit [2:0] pend, input bit [2:0] en);
    int w;
    bit [2:0] left;
    pend_wr = 1; pend_wdata = pend; en_wr = 1; en_wdata = {5'b0, en};
    order_wr = 1; order_wdata = 3'(code);
    nclk(1);
    pend_wr = 0; en_wr = 0; order_wr = 0; gie_set = 1;
    nclk(1);
    gie_set = 0;
    nclk(1);
    w = exp_win(code, pend & en);
    left = pend;
    if (w >= 0) left[w] = 1'b0;
    // R6 R7 R8
    chk(grant == (w >= 0), "R6/R7/R8 grant", grant, w >= 0);
    if (w >= 0) begin
      chk(grant_src == 2'(w), "R7 winner", grant_src, w);
      chk(vec_addr == 16'(exp_vec(w)), "R9 vector", vec_addr, exp_vec(w));
    end
    // R10
    chk(pend_q == left, "R10 pending after grant", pend_q, left);
    chk(en_q[7] == (w < 0), "R10 global enable", en_q[7], w < 0);
    gie_clr = 1; pend_wr = 1; pend_wdata = 0;
    nclk(1);
    gie_clr = 0; pend_wr = 0;
    chk(grant == 1'b0, "R6 single pulse", grant, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    nclk(2);
    // R1
    chk(pend_q == 0 && en_q == 0 && order_q == 0, "R1 reset regs", {pend_q, en_q, order_q}, 0);
    chk(grant == 0 && vec_addr == 0, "R1 reset outputs", {grant, vec_addr}, 0);
    rst_n = 1;
    nclk(1);

    // R5 readback
    en_wr = 1; en_wdata = 8'h85; nclk(1); en_wr = 0;
    chk(en_q == 8'h85, "R5 readback", en_q, 8'h85);
    en_wr = 1; en_wdata = 8'hFF; nclk(1); en_wr = 0;
    chk(en_q == 8'h87, "R5 unused bits", en_q, 8'h87);
    gie_clr = 1; en_wr = 1; en_wdata = 8'h00; nclk(1); gie_clr = 0; en_wr = 0;

    // R2 timers, R4 poll with sources disabled
    t0_eoc = 1; nclk(1); t0_eoc = 0;
    chk(pend_q == 3'b010, "R2 timer0 latch", pend_q, 3'b010);
    t1_eoc = 1; nclk(1); t1_eoc = 0;
    chk(pend_q == 3'b110, "R2/R4 timer1 latch", pend_q, 3'b110);
    pend_wr = 1; pend_wdata = 3'b001; nclk(1); pend_wr = 0;
    chk(pend_q == 3'b001, "R4 write replaces", pend_q, 3'b001);
    pend_wr = 1; pend_wdata = 3'b000; nclk(1); pend_wr = 0;

    // R3 pin synchroniser and edge
    ext_req_n = 0;
    nclk(2);
    chk(pend_q[0] == 1'b0, "R3 not early", pend_q[0], 0);
    nclk(1);
    chk(pend_q[0] == 1'b1, "R3 fall latched", pend_q[0], 1);
    pend_wr = 1; pend_wdata = 3'b000; nclk(1); pend_wr = 0;
    nclk(4);
    chk(pend_q[0] == 1'b0, "R3 steady low", pend_q[0], 0);
    ext_req_n = 1;
    nclk(5);
    chk(pend_q[0] == 1'b0, "R3 rise ignored", pend_q[0], 0);

    // R6 R7 R8 R9 R10 sweep of codes against pending sets
    for (int code = 0; code < 8; code++)
      for (int p = 1; p < 8; p++)
        arm_and_check(code, 3'(p), 3'b111);

    // R6 enable sweep under two codes
    for (int m = 0; m < 8; m++) begin
      arm_and_check(4, 3'b111, 3'(m));
      arm_and_check(3, 3'b111, 3'(m));
    end

    // R6 no grant with global enable low
    pend_wr = 1; pend_wdata = 3'b111; en_wr = 1; en_wdata = 8'h07;
    order_wr = 1; order_wdata = 3'd4; nclk(1);
    pend_wr = 0; en_wr = 0; order_wr = 0;
    nclk(2);
    chk(grant == 0 && pend_q == 3'b111, "R6 global disabled", {grant, pend_q}, 7);

    // R11 event collides with grant clear
    pend_wr = 1; pend_wdata = 3'b010; en_wr = 1; en_wdata = 8'h02;
    order_wr = 1; order_wdata = 3'd1; nclk(1);
    pend_wr = 0; en_wr = 0; order_wr = 0; gie_set = 1; nclk(1);
    gie_set = 0; t0_eoc = 1; nclk(1); t0_eoc = 0;
    chk(grant == 1 && grant_src == 2'd1, "R11 grant taken", {grant, grant_src}, 5);
    chk(pend_q == 3'b010, "R11 new event kept", pend_q, 3'b010);

    // R11 event collides with register write
    pend_wr = 1; pend_wdata = 3'b000; t1_eoc = 1; nclk(1); pend_wr = 0; t1_eoc = 0;
    chk(pend_q == 3'b100, "R11 write vs event", pend_q, 3'b100);

    // R10 precedence of commands
    gie_set = 1; gie_clr = 1; nclk(1); gie_set = 0; gie_clr = 0;
    chk(en_q[7] == 1'b0, "R10 clear over set", en_q[7], 0);
    en_wr = 1; en_wdata = 8'h00; gie_set = 1; nclk(1); en_wr = 0; gie_set = 0;
    chk(en_q[7] == 1'b1, "R10 set over write", en_q[7], 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule